// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Register Bank

This block is the configuration store of a multi-channel front-end chip. It holds 98 ten-bit registers. The rest of the chip reads them in parallel to set its bias levels, calibration code, shaping and sampling settings and per-channel thresholds. A single master reaches every chip on a shared serial line. The chips are wired in a chain: each chip's serial output feeds the serial input of the next chip.

Each access is one frame, sent while the frame strobe is high. A frame names one chip by its identifier, one register and one data word. The named chip writes the word, or puts the register contents on its serial output in place of the data field. Every other chip copies the frame, one clock late, to the next chip in the chain. The frame strobe is also passed on one clock late, so downstream chips stay aligned with the delayed data.

Top module: `cfg_chain_bank`

## Requirements
- R1: A frame is 23 bits, most significant bit first, clocked on the rising edge of `sclk` while `frameEn` is high. The first bit is the access type (1 = write, 0 = read), followed by a 5-bit chip identifier, a 7-bit register address and a 10-bit data word. A cycle with `frameEn` low restarts the bit count, so an aborted partial frame has no effect on the next frame.
- R2: A write whose identifier equals `chipId` and whose address is below 98 loads the data word into that register on the edge that captures the 23rd bit. Register i is found at `regs[i*10+9 : i*10]`.
- R3: A write whose identifier differs from `chipId` leaves every register unchanged.
- R4: Apart from the replaced field of R5, `sdo` equals `sdi` delayed by exactly one `sclk` cycle. This covers foreign frames, writes, header bits and idle time.
- R5: On a read addressed to this chip, the 10 `sdo` bits that follow the data-field input bits carry the register contents instead, most significant bit first. They occupy the same cycles that the delayed data field would occupy.
- R6: A write to an address of 98 or above changes no register.
- R7: A read addressed to this chip with an address of 98 or above returns ten zero bits.
- R8: An asynchronous active-low `rstN` clears all registers, `sdo` and `frameOut` at once, without waiting for a clock edge.
- R9: `frameOut` equals `frameEn` delayed by one `sclk` cycle.
- R10: Bits received after the 23rd while `frameEn` stays high are passed through on `sdo` unchanged and cause no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEn | input | 1 | Frame strobe, high for the bits of one frame |
| sdi | input | 1 | Serial data from the master or the previous chip |
| chipId | input | 5 | Identifier of this chip in the chain |
| sdo | output | 1 | Serial data toward the next chip |
| frameOut | output | 1 | Frame strobe delayed one cycle, for the next chip |
| regs | output | 980 | All register contents, register i at bits i*10+9 down to i*10 |

## Verification
The assertions assume three things about the inputs. First, `sdi` and `frameEn` are stable around each rising edge of `sclk`. Second, `chipId` is held constant while a frame is in progress. Third, `frameEn` drops for at least one edge between two frames. The stimulus meets all three: it changes `sdi` and `frameEn` only on falling edges, ties `chipId` to a fixed value, and inserts one low-strobe cycle after every frame, including the aborted and the over-long ones. The only asynchronous event is the mid-cycle reset pulse, which is placed away from any clock edge.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;
  parameter int NUM_REGS = 98;
  parameter int REG_W    = 10;
  parameter int ID_W     = 5;
  parameter int ADDR_W   = 7;

  localparam int HDR_LEN   = 1 + ID_W + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + REG_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = $clog2(REG_W);
  localparam int FLAT_W    = NUM_REGS * REG_W;

  // strobes from the frame controller to the register datapath
  typedef struct packed {
    logic              wrStb;     // commit wrData to register addr this edge
    logic              rdActive;  // replace serial output with read bit
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  bitIdx;    // register bit to drive on this edge
    logic [REG_W-1:0]  wrData;
  } strobe_t;
endpackage

// File: rtl/cfgchain_ctrl.sv
module cfgchain_ctrl
  import cfgchain_pkg::*;
(
  input  logic            sclk,
  input  logic            rstN,
  input  logic            frameEn,
  input  logic            sdi,
  input  logic [ID_W-1:0] chipId,
  output strobe_t         stb
);
  logic [CNT_W-1:0]   bitCnt;
  logic [HDR_LEN-1:0] hdrQ;
  logic [REG_W-2:0]   dataQ;
  logic               inData;
  logic               idMatch;
  logic               hdrWrite;
  logic               addrOk;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      hdrQ   <= '0;
      dataQ  <= '0;
    end else if (!frameEn) begin
      bitCnt <= '0;
    end else begin
      if (int'(bitCnt) < FRAME_LEN) bitCnt <= bitCnt + 1'b1;
      if (int'(bitCnt) < HDR_LEN) hdrQ <= {hdrQ[HDR_LEN-2:0], sdi};
      else if (int'(bitCnt) < FRAME_LEN) dataQ <= {dataQ[REG_W-3:0], sdi};
    end
  end

  always_comb begin
    inData   = frameEn && int'(bitCnt) >= HDR_LEN && int'(bitCnt) < FRAME_LEN;
    hdrWrite = hdrQ[HDR_LEN-1];
    idMatch  = hdrQ[HDR_LEN-2 -: ID_W] == chipId;
    addrOk   = int'(hdrQ[ADDR_W-1:0]) < NUM_REGS;
    stb.addr     = hdrQ[ADDR_W-1:0];
    stb.wrData   = {dataQ, sdi};
    stb.wrStb    = inData && int'(bitCnt) == FRAME_LEN - 1 && hdrWrite && idMatch && addrOk;
    stb.rdActive = inData && !hdrWrite && idMatch;
    stb.bitIdx   = IDX_W'(CNT_W'(FRAME_LEN - 1) - bitCnt);
  end

  p_cnt_bound_r10: assert property (@(posedge sclk) disable iff (!rstN)
    int'(bitCnt) <= FRAME_LEN);
  p_restart_r1: assert property (@(posedge sclk) disable iff (!rstN)
    !frameEn |=> bitCnt == '0);
  p_wr_range_r6: assert property (@(posedge sclk) disable iff (!rstN)
    stb.wrStb |-> int'(stb.addr) < NUM_REGS);
  p_single_wr_r10: assert property (@(posedge sclk) disable iff (!rstN)
    stb.wrStb |=> !stb.wrStb);
endmodule

// File: rtl/cfgchain_regs.sv
module cfgchain_regs
  import cfgchain_pkg::*;
(
  input  logic              sclk,
  input  logic              rstN,
  input  logic              sdi,
  input  strobe_t           stb,
  output logic              sdo,
  output logic [FLAT_W-1:0] regFlat
);
  logic [REG_W-1:0] rdWord;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [REG_W-1:0] q;
    always_ff @(posedge sclk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.wrStb && int'(stb.addr) == g) q <= stb.wrData;
    end
    assign regFlat[g*REG_W +: REG_W] = q;
  end

  // out-of-range addresses fall through to zero
  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(stb.addr) == i) rdWord = regFlat[i*REG_W +: REG_W];
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) sdo <= 1'b0;
    else sdo <= stb.rdActive ? rdWord[stb.bitIdx] : sdi;
  end

  p_hold_r3: assert property (@(posedge sclk) disable iff (!rstN)
    !stb.wrStb |=> $stable(regFlat));
  p_write_r2: assert property (@(posedge sclk) disable iff (!rstN)
    stb.wrStb |=> regFlat[$past(stb.addr)*REG_W +: REG_W] == $past(stb.wrData));
  p_bypass_r4: assert property (@(posedge sclk) disable iff (!rstN)
    !stb.rdActive |=> sdo == $past(sdi));
  p_zero_read_r7: assert property (@(posedge sclk) disable iff (!rstN)
    (stb.rdActive && int'(stb.addr) >= NUM_REGS) |=> !sdo);
endmodule

// File: rtl/cfg_chain_bank.sv
module cfg_chain_bank
  import cfgchain_pkg::*;
(
  input  logic              sclk,
  input  logic              rstN,
  input  logic              frameEn,
  input  logic              sdi,
  input  logic [ID_W-1:0]   chipId,
  output logic              sdo,
  output logic              frameOut,
  output logic [FLAT_W-1:0] regs
);
  strobe_t stb;

  cfgchain_ctrl uCtrl (
    .sclk(sclk), .rstN(rstN), .frameEn(frameEn), .sdi(sdi),
    .chipId(chipId), .stb(stb)
  );

  cfgchain_regs uRegs (
    .sclk(sclk), .rstN(rstN), .sdi(sdi), .stb(stb),
    .sdo(sdo), .regFlat(regs)
  );

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) frameOut <= 1'b0;
    else frameOut <= frameEn;
  end

  p_frame_delay_r9: assert property (@(posedge sclk) disable iff (!rstN)
    1'b1 |=> frameOut == $past(frameEn));
endmodule

// File: tb/cfg_chain_bank_test.sv
module cfg_chain_bank_test;
  localparam int NREG = 98;
  localparam int W    = 10;
  localparam int FW   = NREG * W;
  localparam logic [4:0] MY_ID = 5'd5;

  logic sclk = 1'b0, rstN = 1'b0, frameEn = 1'b0, sdi = 1'b0;
  logic sdo, frameOut;
  logic [FW-1:0] regs;
  logic [FW-1:0] model = '0;
  int total = 0, bad = 0;

  always #5 sclk = ~sclk;

  cfg_chain_bank uut (
    .sclk(sclk), .rstN(rstN), .frameEn(frameEn), .sdi(sdi),
    .chipId(MY_ID), .sdo(sdo), .frameOut(frameOut), .regs(regs)
  );

  // {write, id, addr, data sent, expected read word}
  localparam logic [32:0] VEC [12] = '{
    {1'b1, 5'd5, 7'd3,  10'h2A5, 10'h000},
    {1'b1, 5'd5, 7'd97, 10'h3FF, 10'h000},
    {1'b1, 5'd9, 7'd3,  10'h111, 10'h000},
    {1'b1, 5'd5, 7'd98, 10'h155, 10'h000},
    {1'b1, 5'd5, 7'd127,10'h2AA, 10'h000},
    {1'b0, 5'd5, 7'd3,  10'h155, 10'h2A5},
    {1'b0, 5'd5, 7'd97, 10'h000, 10'h3FF},
    {1'b0, 5'd5, 7'd98, 10'h3FF, 10'h000},
    {1'b0, 5'd5, 7'd0,  10'h3C3, 10'h000},
    {1'b0, 5'd9, 7'd3,  10'h0F0, 10'h000},
    {1'b1, 5'd5, 7'd0,  10'h001, 10'h000},
    {1'b0, 5'd5, 7'd0,  10'h2DB, 10'h001}
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    total++;
    if (regs !== model) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, regs, model);
    end
  endtask

  // sends len bits MSB first; got[len-1-i] is sdo after bit i was clocked
  task automatic shiftBits(input logic [39:0] pat, input int len,
                           output logic [39:0] got, output logic fOk);
    got = '0;
    fOk = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge sclk);
      if (i > 0) begin
        got[len-i] = sdo;
        if (frameOut !== 1'b1) fOk = 1'b0;
      end
      frameEn = 1'b1;
      sdi = pat[len-1-i];
    end
    @(negedge sclk);
    got[0] = sdo;
    if (frameOut !== 1'b1) fOk = 1'b0;
    frameEn = 1'b0;
    sdi = 1'b0;
  endtask

  initial begin
    #1ms;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [39:0] got, exp, pat;
    logic fOk;
    string tag;

    // R8 reset state
    #12;
    chkRegs("R8 regs in reset");
    chk("R8 sdo in reset", {39'b0, sdo}, 40'd0);
    chk("R8 frameOut in reset", {39'b0, frameOut}, 40'd0);
    @(negedge sclk);
    rstN = 1'b1;

    // table of frames, model updated from the requirements
    for (int v = 0; v < 12; v++) begin
      logic wr;
      logic [4:0] id;
      logic [6:0] ad;
      logic [9:0] dat, expd;
      {wr, id, ad, dat, expd} = VEC[v];
      pat = {17'b0, wr, id, ad, dat};
      shiftBits(pat, 23, got, fOk);
      if (!wr && id == MY_ID) begin
        exp = {17'b0, wr, id, ad, expd};
        tag = (ad >= 7'd98) ? "R7 out-of-range read" : "R5 read data";
      end else begin
        exp = pat;
        tag = "R4 pass-through";
      end
      chk(tag, got, exp);
      if (wr && id == MY_ID && ad < 7'd98) begin
        model[ad*W +: W] = dat;
        tag = "R2 write";
      end else if (wr && id != MY_ID) tag = "R3 foreign write";
      else if (wr) tag = "R6 out-of-range write";
      else tag = "R2 read leaves regs";
      chkRegs(tag);
      chk("R9 frameOut", {39'b0, fOk}, 40'd1);
    end

    // R1 aborted partial frame must not disturb the next one
    shiftBits({30'b0, 1'b1, 5'd5, 4'b0000}, 10, got, fOk);
    shiftBits({17'b0, 1'b1, 5'd5, 7'd20, 10'h0AB}, 23, got, fOk);
    model[20*W +: W] = 10'h0AB;
    chkRegs("R1 restart after abort");

    // R10 over-long frame: one write, extra bits pass through
    pat = {10'b0, 1'b1, 5'd5, 7'd10, 10'h2C3, 7'b1011001};
    shiftBits(pat, 30, got, fOk);
    model[10*W +: W] = 10'h2C3;
    chkRegs("R10 single write on long frame");
    chk("R10 extra bits pass through", got, pat);

    // R8 asynchronous reset between edges
    @(negedge sclk);
    sdi = 1'b1;
    @(posedge sclk);
    #2;
    rstN = 1'b0;
    #1;
    model = '0;
    chkRegs("R8 async clear");
    chk("R8 async sdo", {39'b0, sdo}, 40'd0);
    @(negedge sclk);
    sdi = 1'b0;
    rstN = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule